// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupt Sensing

This block serves several 32-pin general purpose I/O banks behind one word-addressed register bus. For each bank it holds an output value, a drive-enable mask, a synchronized view of the pin inputs, and a per-pin interrupt sensing path. Each pin can flag a rising edge, a falling edge, a high level or a low level into a sticky status bit. Every bank raises its own interrupt line from the status bits that are unmasked.

Every writable register has four write views: plain, set-bits, clear-bits and toggle-bits. Software can then change single pins without a read-modify-write sequence and needs no lock. Interrupt sensing has two separate gates. A per-pin capture select decides whether events reach the status register at all. A per-pin unmask bit only gates the bank's interrupt line. Masking a pin therefore never drops a pulse, and the capture select can stay on whatever the pin is used for.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register of every bank reads 0, and `pin_o`, `pin_oe_o` and `irq_o` are all 0.
- R2: Address bits [12:8] select the register group: 0x07 output value, 0x09 pin input, 0x0B drive enable, 0x10 capture select, 0x11 unmask, 0x12 sense kind, 0x13 sense polarity, 0x14 status. Bits [7:4] select the bank. Bits [3:2] select the write view. A read of any view returns the register. Any other group, or a bank index of `NUM_BANKS` or above, reads 0 and ignores writes.
- R3: On the writable groups, view 0 (+0x0) loads the write data, view 1 (+0x4) ORs it in, view 2 (+0x8) clears the bits that are 1 in it, and view 3 (+0xC) inverts the bits that are 1 in it.
- R4: `pin_oe_o` equals the drive-enable register, and each `pin_o` bit equals its output value bit ANDed with its drive-enable bit.
- R5: The pin input group returns each pin two clock edges after it was sampled, and writes to that group are ignored.
- R6: With sense kind bit 0, a pin latches status on a synchronized edge: a rising edge when the polarity bit is 1 (code 2), a falling edge when it is 0 (code 0). The status bit reads 1 on the third clock edge after the pin changes.
- R7: With sense kind bit 1, a pin latches status on every cycle that its synchronized value equals its polarity bit (code 3 high, code 1 low).
- R8: A pin whose capture select bit is 0 never sets its status bit.
- R9: Status bits are sticky. Only a write of 1 through the clear view (+0x8) of the status group clears them. Plain, set and toggle writes to the status group have no effect.
- R10: When a status clear and a sensed event hit the same bit in the same cycle, the bit stays 1.
- R11: `irq_o[b]` is 1 exactly when bank b has a status bit that is 1 and whose unmask bit is 1. Clearing an unmask bit does not stop status capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 13 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | PINS | Write data |
| bus_rdata_o | output | PINS | Read data, combinational from address |
| pin_i | input | NUM_BANKS*PINS | Pin inputs, bank b at bits [b*PINS +: PINS] |
| pin_o | output | NUM_BANKS*PINS | Output values, gated by drive enable |
| pin_oe_o | output | NUM_BANKS*PINS | Drive enables |
| irq_o | output | NUM_BANKS | Per-bank interrupt line |

## Verification
The acknowledge path and the sensing path both write the status register, and they can act in the same cycle. The bench holds a pin in its active level and writes the clear view on the status bit while that level is still sensed; the bit must read 1 after the write. Random traffic also mixes clear writes with edges and levels on many pins. A cycle model in the bench computes every status bit from the pin history and the write stream, and each read and each interrupt line is compared with that model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W  = 13;
  localparam int NUM_GRP = 8;

  typedef enum logic [1:0] {
    WR_PLAIN = 2'd0,
    WR_SET   = 2'd1,
    WR_CLR   = 2'd2,
    WR_TGL   = 2'd3
  } wr_kind_e;

  typedef enum logic [2:0] {
    G_DOUT = 3'd0,
    G_DIN  = 3'd1,
    G_DOE  = 3'd2,
    G_SEL  = 3'd3,
    G_IEN  = 3'd4,
    G_LEV  = 3'd5,
    G_POL  = 3'd6,
    G_STAT = 3'd7
  } grp_e;

  function automatic logic [ADDR_W-1:0] grp_base(input logic [2:0] g);
    case (g)
      3'd0:    return 13'h0700;
      3'd1:    return 13'h0900;
      3'd2:    return 13'h0B00;
      3'd3:    return 13'h1000;
      3'd4:    return 13'h1100;
      3'd5:    return 13'h1200;
      3'd6:    return 13'h1300;
      default: return 13'h1400;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int PINS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] sync_i,
  input  logic [PINS-1:0] sel_i,
  input  logic [PINS-1:0] lev_i,
  input  logic [PINS-1:0] pol_i,
  input  logic [PINS-1:0] clr_i,
  output logic [PINS-1:0] stat_o
);
  logic [PINS-1:0] prev_q, stat_q, evt, set_w;

  always_comb begin
    for (int p = 0; p < PINS; p++) begin
      if (lev_i[p]) evt[p] = (sync_i[p] == pol_i[p]);
      else          evt[p] = pol_i[p] ? (sync_i[p] & ~prev_q[p]) : (~sync_i[p] & prev_q[p]);
    end
  end

  assign set_w = sel_i & evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sync_i;
      stat_q <= (stat_q & ~clr_i) | set_w;  // set beats clear
    end
  end

  assign stat_o = stat_q;

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

  assert_unselected_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(sel_i)) == '0));

  assert_level_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(sel_i & lev_i & ~(sync_i ^ pol_i)))
              == $past(sel_i & lev_i & ~(sync_i ^ pol_i))));

  assert_set_beats_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(set_w)) == $past(set_w)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pin_i,
  input  logic            wr_en_i,
  input  grp_e            wr_grp_i,
  input  wr_kind_e        wr_kind_i,
  input  logic [PINS-1:0] wdata_i,
  input  grp_e            rd_grp_i,
  output logic [PINS-1:0] rdata_o,
  output logic [PINS-1:0] pin_o,
  output logic [PINS-1:0] pin_oe_o,
  output logic            irq_o
);
  logic [PINS-1:0] cfg_q [NUM_GRP];
  logic [PINS-1:0] din, stat, stat_clr;

  function automatic logic [PINS-1:0] apply_wr(input logic [PINS-1:0] cur,
                                               input logic [PINS-1:0] wd,
                                               input wr_kind_e k);
    case (k)
      WR_PLAIN: return wd;
      WR_SET:   return cur | wd;
      WR_CLR:   return cur & ~wd;
      default:  return cur ^ wd;
    endcase
  endfunction

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_GRP; g++) cfg_q[g] <= '0;
    end else begin
      for (int g = 0; g < NUM_GRP; g++)
        if (wr_en_i && wr_grp_i == grp_e'(g) && grp_e'(g) != G_DIN && grp_e'(g) != G_STAT)
          cfg_q[g] <= apply_wr(cfg_q[g], wdata_i, wr_kind_i);
    end
  end

  assign stat_clr = (wr_en_i && wr_grp_i == G_STAT && wr_kind_i == WR_CLR) ? wdata_i : '0;

  gpio_irq_sense #(.PINS(PINS)) i_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(din),
    .sel_i (cfg_q[G_SEL]),
    .lev_i (cfg_q[G_LEV]),
    .pol_i (cfg_q[G_POL]),
    .clr_i (stat_clr),
    .stat_o(stat)
  );

  always_comb begin
    case (rd_grp_i)
      G_DIN:   rdata_o = din;
      G_STAT:  rdata_o = stat;
      default: rdata_o = cfg_q[rd_grp_i];
    endcase
  end

  assign pin_oe_o = cfg_q[G_DOE];
  assign pin_o    = cfg_q[G_DOUT] & cfg_q[G_DOE];
  assign irq_o    = |(stat & cfg_q[G_IEN]);

  assert_set_view_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_grp_i == G_DOE && wr_kind_i == WR_SET)
      |=> ((cfg_q[G_DOE] & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_view_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_grp_i == G_DOE && wr_kind_i == WR_CLR)
      |=> ((cfg_q[G_DOE] & $past(wdata_i)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic                      bus_we_i,
  input  logic [PINS-1:0]           bus_wdata_i,
  output logic [PINS-1:0]           bus_rdata_o,
  input  logic [NUM_BANKS*PINS-1:0] pin_i,
  output logic [NUM_BANKS*PINS-1:0] pin_o,
  output logic [NUM_BANKS*PINS-1:0] pin_oe_o,
  output logic [NUM_BANKS-1:0]      irq_o
);
  localparam int BANK_W = 4;

  logic              grp_hit;
  grp_e              grp;
  logic [BANK_W-1:0] bank_idx;
  wr_kind_e          kind;
  logic [PINS-1:0]   bank_rdata [NUM_BANKS];
  logic              unused_addr;

  assign bank_idx    = bus_addr_i[7:4];
  assign kind        = wr_kind_e'(bus_addr_i[3:2]);
  assign unused_addr = ^bus_addr_i[1:0];

  always_comb begin
    logic [ADDR_W-1:0] b;
    grp_hit = 1'b0;
    grp     = G_DOUT;
    for (int g = 0; g < NUM_GRP; g++) begin
      b = grp_base(3'(g));
      if (bus_addr_i[ADDR_W-1:8] == b[ADDR_W-1:8]) begin
        grp_hit = 1'b1;
        grp     = grp_e'(g);
      end
    end
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic sel;
    assign sel = grp_hit && (bank_idx == BANK_W'(k));

    gpio_bank #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[k*PINS +: PINS]),
      .wr_en_i  (bus_we_i && sel),
      .wr_grp_i (grp),
      .wr_kind_i(kind),
      .wdata_i  (bus_wdata_i),
      .rd_grp_i (grp),
      .rdata_o  (bank_rdata[k]),
      .pin_o    (pin_o[k*PINS +: PINS]),
      .pin_oe_o (pin_oe_o[k*PINS +: PINS]),
      .irq_o    (irq_o[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (grp_hit && bank_idx == BANK_W'(k)) bus_rdata_o = bank_rdata[k];
  end
endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int PW = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [12:0]       bus_addr_i = '0;
  logic              bus_we_i = 1'b0;
  logic [PW-1:0]     bus_wdata_i = '0;
  logic [PW-1:0]     bus_rdata_o;
  logic [NB*PW-1:0]  pin_i = '0;
  logic [NB*PW-1:0]  pin_o, pin_oe_o;
  logic [NB-1:0]     irq_o;

  int checks = 0;
  int errors = 0;

  logic w_valid = 1'b0;
  int   w_grp = 0, w_bank = 0, w_kind = 0;

  logic [PW-1:0] m_cfg [NB][8];
  logic [PW-1:0] m_s1 [NB];
  logic [PW-1:0] m_s2 [NB];
  logic [PW-1:0] m_prev [NB];

  gpio_bank_ctrl #(.NUM_BANKS(NB), .PINS(PW)) i_gpio_bank_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [12:0] base_of(int g);
    case (g)
      0: return 13'h0700;
      1: return 13'h0900;
      2: return 13'h0B00;
      3: return 13'h1000;
      4: return 13'h1100;
      5: return 13'h1200;
      6: return 13'h1300;
      default: return 13'h1400;
    endcase
  endfunction

  function automatic logic [12:0] addr_of(int g, int b, int k);
    return base_of(g) + 13'(b * 16 + k * 4);
  endfunction

  function automatic logic [PW-1:0] exp_read(logic [12:0] a);
    for (int g = 0; g < 8; g++) begin
      logic [12:0] bs;
      bs = base_of(g);
      if (a[12:8] == bs[12:8] && int'(a[7:4]) < NB)
        return (g == 1) ? m_s2[a[7:4]] : m_cfg[a[7:4]][g];
    end
    return '0;
  endfunction

  // cycle model built from the requirements
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin
        for (int g = 0; g < 8; g++) m_cfg[b][g] = '0;
        m_s1[b] = '0; m_s2[b] = '0; m_prev[b] = '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        logic [PW-1:0] lv, pl, evt, clr, d;
        logic          hit;
        lv  = m_cfg[b][5];
        pl  = m_cfg[b][6];
        evt = (lv & ~(m_s2[b] ^ pl)) | (~lv & pl & m_s2[b] & ~m_prev[b])
            | (~lv & ~pl & ~m_s2[b] & m_prev[b]);
        hit = bus_we_i && w_valid && (w_bank == b);
        clr = (hit && w_grp == 7 && w_kind == 2) ? bus_wdata_i : '0;
        m_cfg[b][7] = (m_cfg[b][7] & ~clr) | (m_cfg[b][3] & evt);
        if (hit && w_grp != 1 && w_grp != 7) begin
          d = m_cfg[b][w_grp];
          case (w_kind)
            0: d = bus_wdata_i;
            1: d = d | bus_wdata_i;
            2: d = d & ~bus_wdata_i;
            default: d = d ^ bus_wdata_i;
          endcase
          m_cfg[b][w_grp] = d;
        end
        m_prev[b] = m_s2[b];
        m_s2[b]   = m_s1[b];
        m_s1[b]   = pin_i[b*PW +: PW];
      end
    end
  end

  task automatic chk(input logic [PW-1:0] act, input logic [PW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_write(input int g, input int b, input int k, input logic [PW-1:0] d);
    bus_addr_i = addr_of(g, b, k); bus_wdata_i = d; bus_we_i = 1'b1;
    w_valid = (b < NB); w_grp = g; w_bank = b; w_kind = k;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input int g, input int b, input int k, output logic [PW-1:0] v);
    bus_we_i = 1'b0; bus_addr_i = addr_of(g, b, k);
    #1 v = bus_rdata_o;
  endtask

  task automatic check_outputs();
    for (int b = 0; b < NB; b++) begin
      chk(32'(irq_o[b]), 32'(|(m_cfg[b][7] & m_cfg[b][4])), "R11 irq line");
      chk(pin_o[b*PW +: PW], m_cfg[b][0] & m_cfg[b][2], "R4 pin value");
      chk(pin_oe_o[b*PW +: PW], m_cfg[b][2], "R4 drive enable");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [PW-1:0] v;
    logic [12:0]   a;
    v = $urandom(32'h5eed);
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    chk(32'(irq_o), 0, "R1 irq after reset");
    chk(pin_o[PW-1:0], 0, "R1 pin_o after reset");
    chk(pin_oe_o[2*PW +: PW], 0, "R1 pin_oe_o after reset");
    rd(7, 1, 0, v); chk(v, 0, "R1 status after reset");

    // R2 decode
    bus_addr_i = 13'h0000; #1 chk(bus_rdata_o, 0, "R2 unmapped read");
    do_write(0, NB, 0, 32'hFFFF_FFFF);
    do_write(2, NB, 0, 32'hFFFF_FFFF);
    rd(0, NB, 0, v); chk(v, 0, "R2 out of range bank read");
    chk(pin_oe_o[PW-1:0], 0, "R2 out of range write ignored");

    // R3 / R4 write views
    do_write(0, 1, 0, 32'hFFFF_0000);
    do_write(2, 1, 1, 32'h00FF_00FF);
    chk(pin_o[PW +: PW], 32'h00FF_0000, "R4 pin_o gated");
    chk(pin_oe_o[PW +: PW], 32'h00FF_00FF, "R3 set view");
    do_write(2, 1, 3, 32'h0000_FFFF);
    rd(2, 1, 0, v); chk(v, 32'h00FF_FF00, "R3 toggle view");
    do_write(0, 1, 2, 32'hF000_0000);
    rd(0, 1, 2, v); chk(v, 32'h0FFF_0000, "R3 clear view, read via alias");

    // R5 synchronizer latency
    pin_i[PW-1:0] = 32'hA5A5_A5A5;
    tick(1); rd(1, 0, 0, v); chk(v, 0, "R5 input after one edge");
    tick(1); rd(1, 0, 0, v); chk(v, 32'hA5A5_A5A5, "R5 input after two edges");
    do_write(1, 0, 0, 32'h0);
    rd(1, 0, 0, v); chk(v, 32'hA5A5_A5A5, "R5 write to input ignored");

    // R6 rising edge on bank2 pin0
    do_write(3, 2, 1, 32'h1);
    do_write(6, 2, 1, 32'h1);
    pin_i[2*PW + 0] = 1'b1;
    tick(2); rd(7, 2, 0, v); chk(v, 0, "R6 rising not yet visible");
    tick(1); rd(7, 2, 0, v); chk(v, 32'h1, "R6 rising latched on third edge");
    do_write(7, 2, 2, 32'h1);
    tick(2); rd(7, 2, 0, v); chk(v, 0, "R6 edge does not relatch");

    // R6 falling edge with mask off, R11
    do_write(3, 2, 1, 32'h2);
    pin_i[2*PW + 1] = 1'b1;
    tick(3); rd(7, 2, 0, v); chk(v, 0, "R6 rise ignored in falling mode");
    pin_i[2*PW + 1] = 1'b0;
    tick(3); rd(7, 2, 0, v); chk(v, 32'h2, "R11 masked falling pulse latched");
    chk(32'(irq_o[2]), 0, "R11 masked line low");

    // R9 ignored status writes
    do_write(7, 2, 0, 32'h0);
    do_write(7, 2, 3, 32'h2);
    do_write(7, 2, 1, 32'hFFFF_0000);
    rd(7, 2, 0, v); chk(v, 32'h2, "R9 plain/toggle/set ignored on status");

    do_write(4, 2, 1, 32'h2);
    chk(32'(irq_o[2]), 1, "R11 unmask raises line");
    do_write(7, 2, 2, 32'h2);
    chk(32'(irq_o[2]), 0, "R11 acknowledge drops line");

    // R7 / R10 high level on bank0 pin3
    do_write(6, 0, 1, 32'h8);
    do_write(5, 0, 1, 32'h8);
    do_write(3, 0, 1, 32'h8);
    rd(7, 0, 0, v); chk(v, 0, "R7 level not met");
    pin_i[3] = 1'b1;
    tick(3); rd(7, 0, 0, v); chk(v, 32'h8, "R7 high level latched");
    do_write(7, 0, 2, 32'h8);
    rd(7, 0, 0, v); chk(v, 32'h8, "R10 set beats clear");
    pin_i[3] = 1'b0;
    tick(3);
    do_write(7, 0, 2, 32'h8);
    tick(2); rd(7, 0, 0, v); chk(v, 0, "R9 cleared and stays clear");

    // R7 low level, then R8 capture select off
    do_write(6, 0, 2, 32'h8);
    tick(2); rd(7, 0, 0, v); chk(v, 32'h8, "R7 low level latched");
    do_write(3, 0, 2, 32'h8);
    do_write(7, 0, 2, 32'h8);
    tick(3); rd(7, 0, 0, v); chk(v, 0, "R8 deselected pin stays clear");
    do_write(6, 1, 1, 32'h20);
    pin_i[PW + 5] = 1'b1;
    tick(4); rd(7, 1, 0, v); chk(v, 0, "R8 deselected rising edge");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk_i);
      bus_we_i = 1'b0;
      check_outputs();
      op = int'($urandom_range(0, 9));
      if (op <= 5) begin
        int g, b;
        g = int'($urandom_range(0, 7));
        b = (op == 5) ? NB : int'($urandom_range(0, NB - 1));
        w_valid = (b < NB); w_grp = g; w_bank = b; w_kind = int'($urandom_range(0, 3));
        bus_addr_i = addr_of(g, b, w_kind);
        bus_wdata_i = (g == 5 || g == 6) ? ($urandom & $urandom) : $urandom;
        bus_we_i = 1'b1;
      end else begin
        a = (op == 9) ? 13'($urandom) : addr_of(int'($urandom_range(0, 7)),
                                                int'($urandom_range(0, NB - 1)),
                                                int'($urandom_range(0, 3)));
        bus_addr_i = a;
        #1;
        case (int'(a[12:8]))
          9:       chk(bus_rdata_o, exp_read(a), "R5 input read");
          20:      chk(bus_rdata_o, exp_read(a), "R6 R7 R9 R10 status read");
          default: chk(bus_rdata_o, exp_read(a), "R2 R3 register read");
        endcase
      end
      if ($urandom_range(0, 2) == 0)
        pin_i = pin_i ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                         & {$urandom, $urandom, $urandom});
    end
    @(negedge clk_i);
    bus_we_i = 1'b0;
    check_outputs();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule